// File: doc/BRIEF.md
# Retimer Control Register Bank with Two-Wire Target

This block holds the configuration and status registers of a three-channel serial-link retimer. A host reaches it over a two-wire bus, I2C-style. The block contains a byte-level target engine that recognises its own 7-bit bus address, taken from strap inputs. It also keeps a register pointer that the host loads and that advances after every byte.

Four registers are implemented:

- an identity byte, which is read-only;
- a live status byte, which is read-only and reports whether a clock is present on the link input;
- a channel-control byte, which carries the power-down request and the self-clearing soft-reset request;
- an input-control byte, which drives the input tri-state, activity-detect mode, hysteresis and recalibration outputs.

The power-down output combines the register bit with an external pin. The serial port keeps working while power-down is active.

SCL and SDA are sampled on a system clock that runs at least ten times faster than SCL. The block drives SDA only as an open-drain pull-down enable.

Top module: `regen_ctrl_regs`

## Requirements
- R1: After reset the channel-control byte reads 0x0C and the input-control byte reads 0x12. In that state `clk_in_tri`, `data_in_tri`, `hyst_en`, `hyst_20mv`, `recal_req` and `soft_rst_out` are 0, `detect_mode` is 1, `sda_oe` is 0, and `pd_out` equals `pd_pin`.
- R2: The target acknowledges only an address byte whose upper seven bits equal `dev_addr`; bit 0 of that byte is 1 for a read. After a non-matching address it acknowledges nothing and changes nothing until the next START.
- R3: In a write, the first byte after the address loads the register pointer. Each following data byte goes to the pointer, and the pointer then increments. Each byte read also increments the pointer. A read begins at the current pointer, whether it follows a repeated START or a separate transaction.
- R4: Register 0x00 reads 0x31: identifier 3 in bits [7:4] and revision 1 in bits [3:0]. Writes to 0x00 and 0x01 are acknowledged and have no effect.
- R5: Register 0x01 bit 2 follows `clk_detect` (1 = clock present). All its other bits read 0.
- R6: Register 0x02 bits [3:0] always read 0xC and bits [7:6] always read 0, whatever is written.
- R7: `pd_out` is 1 whenever register 0x02 bit 5 is 1 or `pd_pin` is 1, and 0 otherwise.
- R8: Writing 1 to register 0x02 bit 4 raises `soft_rst_out` for exactly 16 system clocks. During that pulse, registers 0x02 and 0x03 return to their reset values. Afterwards bit 4 reads 0.
- R9: Register 0x03 is a full read/write byte. Its bits drive these outputs: bit 2 `clk_in_tri`, bit 3 `data_in_tri`, bit 4 `detect_mode` (0 = AC activity, 1 = common-mode), bit 5 `hyst_en`, bit 6 `hyst_20mv` (1 = larger step) and bit 7 `recal_req`.
- R10: Register reads and writes work normally while `pd_out` is 1.
- R11: `sda_oe` changes only while SCL is low. Reads from pointers 0x04 and above return 0x00.
- R12: When the host answers a read byte with NACK, the target releases SDA and sends no further bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Two-wire bus clock as seen on the pin |
| sda_in | input | 1 | Two-wire bus data as seen on the pin |
| dev_addr | input | 7 | Strapped target bus address |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| pd_pin | input | 1 | External power-down request |
| clk_detect | input | 1 | Link clock present indication |
| pd_out | output | 1 | Combined power-down |
| soft_rst_out | output | 1 | Self-timed soft-reset pulse |
| clk_in_tri | output | 1 | Tri-state the clock input termination |
| data_in_tri | output | 1 | Tri-state the data input termination |
| detect_mode | output | 1 | Activity-detect method select |
| hyst_en | output | 1 | Clock input hysteresis enable |
| hyst_20mv | output | 1 | Hysteresis magnitude select |
| recal_req | output | 1 | Termination recalibration request |

## Verification
The hardest situation to reach from the ports is a soft-reset pulse that lands on registers already holding non-default values. The pulse must also be observed to restore them while a power-down bit written in the same byte is also cleared. The stimulus first writes non-default input-control values over the bus. It then writes a single channel-control byte that sets both the reset and the power-down bits. A port-side counter measures the pulse width, and read-back over the bus afterwards confirms both registers hold their defaults. Auto-increment across the read-only registers into unimplemented space is reached with one long burst read.

// File: rtl/regen_pkg.sv
// Package: shared constants and types for the retimer control register bank.
// Assumes an 8-bit register pointer and byte-wide registers.
package regen_pkg;

    localparam logic [7:0] PTR_IDENT = 8'h00;
    localparam logic [7:0] PTR_STAT  = 8'h01;
    localparam logic [7:0] PTR_CHAN  = 8'h02;
    localparam logic [7:0] PTR_INCTL = 8'h03;

    localparam logic [3:0] CHAN_FIXED_NIB = 4'hC;
    localparam logic [7:0] INCTL_DEFAULT  = 8'h12;

    // Field layout of the input-control byte, MSB first.
    typedef struct packed {
        logic       recal;
        logic       hyst_big;
        logic       hyst_on;
        logic       det_mode;
        logic       data_tri;
        logic       clk_tri;
        logic [1:0] spare;
    } inctl_t;

    typedef enum logic [2:0] {
        TG_IDLE,
        TG_RX,
        TG_RX_ACK,
        TG_TX,
        TG_TX_ACK
    } tgt_state_t;

endpackage

// File: rtl/regen_line_sync.sv
// Module: regen_line_sync
// Brings the two bus lines into the system clock domain through a
// parameterised flop chain. It then derives SCL edges and START/STOP events,
// which are SDA edges while SCL is high. Assumes the system clock is at least
// 10x SCL and that idle lines are high.
module regen_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // One flop per stage; stage 0 takes the pin.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_p[g] <= 1'b1;
                    sda_p[g] <= 1'b1;
                end else begin
                    scl_p[g] <= scl_raw;
                    sda_p[g] <= sda_raw;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_p[g] <= 1'b1;
                    sda_p[g] <= 1'b1;
                end else begin
                    scl_p[g] <= scl_p[g-1];
                    sda_p[g] <= sda_p[g-1];
                end
            end
        end
    end

    assign scl_s = scl_p[STAGES-1];
    assign sda_s = sda_p[STAGES-1];

    // Hold the previous synchronised values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/regen_i2c_target.sv
// Module: regen_i2c_target
// Byte-level two-wire target engine. It shifts bits in on SCL rises and
// changes SDA only after SCL falls. It acknowledges its own address and
// every written byte. It hands written bytes to the register file, marking
// the first byte as the pointer. In read mode it shifts out rd_data and
// requests a pointer advance after each byte. Assumes the edge and condition
// strobes from regen_line_sync.
module regen_i2c_target
    import regen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] dev_addr,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic       wr_is_ptr,
    output logic [7:0] wr_data,
    output logic       rd_adv
);
    tgt_state_t state;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       addr_phase;
    logic       ptr_phase;
    logic       rd_mode;
    logic       host_ack;

    // Main bus sequencer: bit counting, acknowledge, shift in and shift out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TG_IDLE;
            bit_cnt    <= 4'd0;
            rx_sh      <= 8'h00;
            tx_sh      <= 8'h00;
            addr_phase <= 1'b0;
            ptr_phase  <= 1'b0;
            rd_mode    <= 1'b0;
            host_ack   <= 1'b0;
            sda_oe     <= 1'b0;
            wr_stb     <= 1'b0;
            wr_is_ptr  <= 1'b0;
            wr_data    <= 8'h00;
            rd_adv     <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_adv <= 1'b0;
            if (start_det) begin
                state      <= TG_RX;
                bit_cnt    <= 4'd0;
                addr_phase <= 1'b1;
                sda_oe     <= 1'b0;
            end else if (stop_det) begin
                state  <= TG_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    TG_RX: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (addr_phase) begin
                                if (rx_sh[7:1] == dev_addr) begin
                                    sda_oe    <= 1'b1;
                                    rd_mode   <= rx_sh[0];
                                    ptr_phase <= ~rx_sh[0];
                                    state     <= TG_RX_ACK;
                                end else begin
                                    state <= TG_IDLE;
                                end
                            end else begin
                                sda_oe    <= 1'b1;
                                wr_stb    <= 1'b1;
                                wr_is_ptr <= ptr_phase;
                                wr_data   <= rx_sh;
                                ptr_phase <= 1'b0;
                                state     <= TG_RX_ACK;
                            end
                        end
                    end
                    TG_RX_ACK: begin
                        if (scl_fall) begin
                            bit_cnt    <= 4'd0;
                            addr_phase <= 1'b0;
                            if (rd_mode) begin
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= TG_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= TG_RX;
                            end
                        end
                    end
                    TG_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                rd_adv <= 1'b1;
                                state  <= TG_TX_ACK;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                            end
                        end
                    end
                    TG_TX_ACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            bit_cnt <= 4'd0;
                            if (host_ack) begin
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= TG_TX;
                            end else begin
                                state <= TG_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/regen_regfile.sv
// Module: regen_regfile
// Register storage, pointer and read mux. It holds the power-down bit, the
// soft-reset countdown and the input-control byte. It synchronises the
// clock-present status. Assumes write and advance strobes last one cycle.
module regen_regfile
    import regen_pkg::*;
#(
    parameter logic [3:0] IDENT_NIB  = 4'h3,
    parameter logic [3:0] REV_NIB    = 4'h1,
    parameter int         RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       wr_is_ptr,
    input  logic [7:0] wr_data,
    input  logic       rd_adv,
    input  logic       clk_detect,
    output logic [7:0] rd_data,
    output logic       pd_bit,
    output logic       soft_rst,
    output inctl_t     inctl
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [7:0]    ptr;
    logic [CW-1:0] rst_cnt;
    logic [1:0]    det_sync;
    logic          data_wr;

    assign data_wr  = wr_stb & ~wr_is_ptr;
    assign soft_rst = (rst_cnt != '0);

    // Register pointer: loaded by the first byte, advanced after each data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= 8'h00;
        end else if (wr_stb) begin
            ptr <= wr_is_ptr ? wr_data : ptr + 8'd1;
        end else if (rd_adv) begin
            ptr <= ptr + 8'd1;
        end
    end

    // Soft-reset countdown, started by a write of bit 4 of the channel byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_cnt <= '0;
        end else if (rst_cnt != '0) begin
            rst_cnt <= rst_cnt - CW'(1);
        end else if (data_wr && ptr == PTR_CHAN && wr_data[4]) begin
            rst_cnt <= CW'(RST_CYCLES);
        end
    end

    // Power-down bit and input-control byte; both restored during soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            pd_bit <= 1'b0;
            inctl  <= INCTL_DEFAULT;
        end else if (data_wr) begin
            if (ptr == PTR_CHAN) begin
                pd_bit <= wr_data[5];
            end
            if (ptr == PTR_INCTL) begin
                inctl <= wr_data;
            end
        end
    end

    // Two-flop capture of the asynchronous clock-present status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_sync <= 2'b00;
        end else begin
            det_sync <= {det_sync[0], clk_detect};
        end
    end

    // Read mux over the pointer; unimplemented space reads zero.
    always_comb begin
        case (ptr)
            PTR_IDENT: rd_data = {IDENT_NIB, REV_NIB};
            PTR_STAT:  rd_data = {5'b00000, det_sync[1], 2'b00};
            PTR_CHAN:  rd_data = {2'b00, pd_bit, soft_rst, CHAN_FIXED_NIB};
            PTR_INCTL: rd_data = inctl;
            default:   rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/regen_ctrl_regs.sv
// Module: regen_ctrl_regs (top)
// Control register bank of a three-channel retimer, reached over a two-wire
// target port. It joins the line synchroniser, the byte engine and the
// register file, and merges the power-down pin. Assumes the system clock is at
// least 10x SCL and an external pull-up on SDA.
module regen_ctrl_regs
    import regen_pkg::*;
#(
    parameter logic [3:0] IDENT_NIB   = 4'h3,
    parameter logic [3:0] REV_NIB     = 4'h1,
    parameter int         SYNC_STAGES = 2,
    parameter int         RST_CYCLES  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [6:0] dev_addr,
    output logic       sda_oe,
    input  logic       pd_pin,
    input  logic       clk_detect,
    output logic       pd_out,
    output logic       soft_rst_out,
    output logic       clk_in_tri,
    output logic       data_in_tri,
    output logic       detect_mode,
    output logic       hyst_en,
    output logic       hyst_20mv,
    output logic       recal_req
);
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       wr_stb;
    logic       wr_is_ptr;
    logic [7:0] wr_data;
    logic       rd_adv;
    logic [7:0] rd_data;
    logic       pd_bit;
    inctl_t     inctl;

    regen_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    regen_i2c_target i_tgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_addr  (dev_addr),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_stb    (wr_stb),
        .wr_is_ptr (wr_is_ptr),
        .wr_data   (wr_data),
        .rd_adv    (rd_adv)
    );

    regen_regfile #(
        .IDENT_NIB  (IDENT_NIB),
        .REV_NIB    (REV_NIB),
        .RST_CYCLES (RST_CYCLES)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wr_is_ptr  (wr_is_ptr),
        .wr_data    (wr_data),
        .rd_adv     (rd_adv),
        .clk_detect (clk_detect),
        .rd_data    (rd_data),
        .pd_bit     (pd_bit),
        .soft_rst   (soft_rst_out),
        .inctl      (inctl)
    );

    // Output mapping: merged power-down and input-control fields.
    always_comb begin
        pd_out      = pd_bit | pd_pin;
        clk_in_tri  = inctl.clk_tri;
        data_in_tri = inctl.data_tri;
        detect_mode = inctl.det_mode;
        hyst_en     = inctl.hyst_on;
        hyst_20mv   = inctl.hyst_big;
        recal_req   = inctl.recal;
    end

endmodule

// File: rtl/regen_ctrl_regs_chk.sv
// Module: regen_ctrl_regs_chk
// Property checker bound to regen_ctrl_regs. It watches the pulse width, the
// restore of defaults, the power-down merge and the SDA drive timing.
module regen_ctrl_regs_chk #(
    parameter int RST_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_oe,
    input logic pd_pin,
    input logic pd_out,
    input logic soft_rst_out,
    input logic clk_in_tri,
    input logic data_in_tri,
    input logic detect_mode,
    input logic hyst_en,
    input logic hyst_20mv,
    input logic recal_req
);
    localparam int HW = $clog2(RST_CYCLES + 2) + 1;

    logic [HW-1:0] hi_cnt;

    // Count consecutive cycles with the soft-reset output high.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_out) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + HW'(1);
        end
    end

    p_pd_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pd_pin |-> pd_out);

    p_rst_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst_out && $past(soft_rst_out)) |-> (hi_cnt == HW'(RST_CYCLES)));

    p_rst_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_out && $past(soft_rst_out)) |->
            (!clk_in_tri && !data_in_tri && detect_mode && !hyst_en &&
             !hyst_20mv && !recal_req && (pd_out == pd_pin)));

    p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in);

endmodule

bind regen_ctrl_regs regen_ctrl_regs_chk #(.RST_CYCLES(RST_CYCLES)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_in),
    .sda_oe       (sda_oe),
    .pd_pin       (pd_pin),
    .pd_out       (pd_out),
    .soft_rst_out (soft_rst_out),
    .clk_in_tri   (clk_in_tri),
    .data_in_tri  (data_in_tri),
    .detect_mode  (detect_mode),
    .hyst_en      (hyst_en),
    .hyst_20mv    (hyst_20mv),
    .recal_req    (recal_req)
);

// File: tb/test_regen_ctrl_regs.sv
// Scoreboard bench: bus read tasks push observed bytes, a monitor compares them
// against expectations queued by the driver; port checks go straight to chk.
module test_regen_ctrl_regs;
    localparam int HT = 20;
    localparam int QT = 5;
    localparam logic [6:0] ADDR = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic pd_pin = 1'b0;
    logic clk_detect = 1'b0;
    logic sda_oe, pd_out, soft_rst_out, clk_in_tri, data_in_tri;
    logic detect_mode, hyst_en, hyst_20mv, recal_req;
    wire  sda_bus = !(m_sda_low || sda_oe);

    int n_chk = 0;
    int n_fail = 0;
    int hi_run = 0;
    int last_w = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] act_q[$];
    event       got_ev;

    always #2 clk = ~clk;

    regen_ctrl_regs i_regen_ctrl_regs (
        .clk (clk), .rst_n (rst_n), .scl_in (m_scl), .sda_in (sda_bus),
        .dev_addr (ADDR), .sda_oe (sda_oe), .pd_pin (pd_pin),
        .clk_detect (clk_detect), .pd_out (pd_out), .soft_rst_out (soft_rst_out),
        .clk_in_tri (clk_in_tri), .data_in_tri (data_in_tri),
        .detect_mode (detect_mode), .hyst_en (hyst_en), .hyst_20mv (hyst_20mv),
        .recal_req (recal_req)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Port-side measure of the soft-reset pulse width.
    always @(negedge clk) begin
        if (soft_rst_out) hi_run = hi_run + 1;
        else begin
            if (hi_run != 0) last_w = hi_run;
            hi_run = 0;
        end
    end

    // Monitor: pop observed bytes and compare with the expected queue.
    initial begin
        forever begin
            @(got_ev);
            while (act_q.size() > 0) begin
                logic [7:0] a;
                a = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R3 actual=%0h expected=none", a);
                end else begin
                    chk(tag_q.pop_front(), {24'h0, a}, {24'h0, exp_q.pop_front()});
                end
            end
        end
    end

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic b_start();
        m_sda_low = 1'b1; wt(HT); m_scl = 1'b0;
    endtask

    task automatic b_rstart();
        wt(QT); m_sda_low = 1'b0; wt(HT - QT); m_scl = 1'b1; wt(HT);
        m_sda_low = 1'b1; wt(HT); m_scl = 1'b0;
    endtask

    task automatic b_stop();
        wt(QT); m_sda_low = 1'b1; wt(HT - QT); m_scl = 1'b1; wt(HT);
        m_sda_low = 1'b0; wt(HT);
    endtask

    task automatic b_wr(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            wt(QT); m_sda_low = !b[i]; wt(HT - QT); m_scl = 1'b1; wt(HT); m_scl = 1'b0;
        end
        wt(QT); m_sda_low = 1'b0; wt(HT - QT); m_scl = 1'b1;
        wt(HT / 2); ack = !sda_bus; wt(HT / 2); m_scl = 1'b0;
    endtask

    task automatic b_rd(input bit give_ack);
        logic [7:0] b;
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wt(HT); m_scl = 1'b1; wt(HT / 2); b[i] = sda_bus; wt(HT / 2); m_scl = 1'b0;
        end
        wt(QT); m_sda_low = give_ack; wt(HT - QT); m_scl = 1'b1; wt(HT); m_scl = 1'b0;
        wt(QT); m_sda_low = 1'b0;
        act_q.push_back(b);
        ->got_ev;
        if (!give_ack) begin
            wt(QT);
            chk("R12", {31'h0, sda_oe}, 32'h0);
        end
    endtask

    task automatic wr_regs(input logic [7:0] ptr, input logic [7:0] d[4],
                           input int n, input string req);
        bit ack;
        b_start();
        b_wr({ADDR, 1'b0}, ack); chk(req, {31'h0, ack}, 32'h1);
        b_wr(ptr, ack);          chk(req, {31'h0, ack}, 32'h1);
        for (int i = 0; i < n; i++) begin
            b_wr(d[i], ack); chk(req, {31'h0, ack}, 32'h1);
        end
        b_stop();
    endtask

    task automatic rd_regs(input logic [7:0] ptr, input logic [7:0] e[5],
                           input int n, input string req);
        bit ack;
        for (int i = 0; i < n; i++) expect_byte(e[i], req);
        b_start();
        b_wr({ADDR, 1'b0}, ack); chk(req, {31'h0, ack}, 32'h1);
        b_wr(ptr, ack);          chk(req, {31'h0, ack}, 32'h1);
        b_rstart();
        b_wr({ADDR, 1'b1}, ack); chk(req, {31'h0, ack}, 32'h1);
        for (int i = 0; i < n; i++) b_rd(i != n - 1);
        b_stop();
    endtask

    task automatic chk_inctl(input logic [7:0] v, input string req);
        chk(req, {26'h0, recal_req, hyst_20mv, hyst_en, detect_mode, data_in_tri, clk_in_tri},
            {26'h0, v[7:2]});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        wt(4000 * 40);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        bit ack;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        // R1: reset state at the ports and over the bus
        chk_inctl(8'h12, "R1");
        chk("R1", {29'h0, soft_rst_out, sda_oe, pd_out}, 32'h0);
        rd_regs(8'h02, '{8'h0C, 8'h12, 0, 0, 0}, 2, "R1");

        // R4, R5: identity and live status
        rd_regs(8'h00, '{8'h31, 0, 0, 0, 0}, 1, "R4");
        rd_regs(8'h01, '{8'h00, 0, 0, 0, 0}, 1, "R5");
        clk_detect = 1'b1; wt(5);
        rd_regs(8'h01, '{8'h04, 0, 0, 0, 0}, 1, "R5");

        // R2: foreign address is not acknowledged and changes nothing
        b_start();
        b_wr({7'h5B, 1'b0}, ack); chk("R2", {31'h0, ack}, 32'h0);
        b_wr(8'h03, ack); chk("R2", {31'h0, ack}, 32'h0);
        b_wr(8'hFF, ack);
        b_stop();
        chk_inctl(8'h12, "R2");
        rd_regs(8'h03, '{8'h12, 0, 0, 0, 0}, 1, "R2");

        // R9: input-control fields
        wr_regs(8'h03, '{8'h63, 0, 0, 0}, 1, "R9");
        chk_inctl(8'h63, "R9");
        rd_regs(8'h03, '{8'h63, 0, 0, 0, 0}, 1, "R9");

        // R3: burst read across all registers; R11: unimplemented reads zero
        rd_regs(8'h00, '{8'h31, 8'h04, 8'h0C, 8'h63, 8'h00}, 5, "R3");
        rd_regs(8'h07, '{8'h00, 0, 0, 0, 0}, 1, "R11");

        // R3: pointer-only write, then a separate read from the current pointer
        wr_regs(8'h03, '{0, 0, 0, 0}, 0, "R3");
        expect_byte(8'h63, "R3");
        b_start();
        b_wr({ADDR, 1'b1}, ack); chk("R3", {31'h0, ack}, 32'h1);
        b_rd(1'b0);
        b_stop();

        // R6: fixed bits of the channel byte; R7: power-down from register bit
        wr_regs(8'h02, '{8'hE3, 0, 0, 0}, 1, "R6");
        rd_regs(8'h02, '{8'h2C, 0, 0, 0, 0}, 1, "R6");
        chk("R7", {31'h0, pd_out}, 32'h1);

        // R10: serial port works while powered down
        wr_regs(8'h03, '{8'h9C, 0, 0, 0}, 1, "R10");
        chk_inctl(8'h9C, "R10");
        rd_regs(8'h03, '{8'h9C, 0, 0, 0, 0}, 1, "R10");

        // R7: pin alone, then neither source
        wr_regs(8'h02, '{8'h0C, 0, 0, 0}, 1, "R7");
        chk("R7", {31'h0, pd_out}, 32'h0);
        pd_pin = 1'b1; wt(2);
        chk("R7", {31'h0, pd_out}, 32'h1);
        pd_pin = 1'b0; wt(2);
        chk("R7", {31'h0, pd_out}, 32'h0);

        // R4: writes to read-only registers acknowledged and ignored
        wr_regs(8'h00, '{8'hAA, 8'h55, 0, 0}, 2, "R4");
        rd_regs(8'h00, '{8'h31, 8'h04, 0, 0, 0}, 2, "R4");

        // R3: multi-byte write with auto-increment
        wr_regs(8'h02, '{8'h0C, 8'h5D, 0, 0}, 2, "R3");
        rd_regs(8'h03, '{8'h5D, 0, 0, 0, 0}, 1, "R3");

        // R8: soft reset with power-down in the same byte
        last_w = 0;
        wr_regs(8'h02, '{8'h30, 0, 0, 0}, 1, "R8");
        wt(40);
        chk("R8", last_w, 16);
        chk_inctl(8'h12, "R8");
        chk("R8", {31'h0, pd_out}, 32'h0);
        rd_regs(8'h02, '{8'h0C, 8'h12, 0, 0, 0}, 2, "R8");

        wt(20);
        chk("R3", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule